// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block takes a programmable device from the end of configuration into user operation. It counts configuration clock edges after the initialisation signal rises and compares the count with a length value loaded from the configuration stream. Once that count is reached and the final frame has been written, it releases an open-drain DONE line. It then lifts the global reset on user flip-flops and turns on the user I/O drivers, with a separate delay for each.

Two selections set the timing. The first is the time base: the configuration clock, or rising edges of a user clock. The second is the reference for the two later events. In free mode each event counts edges from the clock edge that released DONE. In locked mode each event waits for the sensed wired-AND DONE level to go high and then counts edges from that point. In locked mode any device on the shared line can hold DONE low and stall start-up. An active-low reprogram pulse returns everything to the configuration state. Mode and delay inputs are held steady while the reprogram input is high.

Top module: `cfg_startup`

## Requirements
- R1: DONE release (`done_pull_o` falling to 0) needs two conditions. The count of `clk_i` edges since `init_i` rose must have reached `len_count_i`, and `frame_end_i` must be high. In configuration-clock modes the release happens on the first edge at which both conditions hold. If `init_i` rises before edge i0+1 and `frame_end_i` is high before edge f+1, DONE is released at edge max(i0+len, f)+1.
- R2: In free modes, reset release (`gsr_o` to 0) and I/O enable (`io_en_o` to 1) each take effect a number of time-base edges after the DONE release edge, where the number is the effective delay of that event. A delay of 0 makes the event fall on the same edge as DONE release.
- R3: In locked modes, `done_sense_i` passes through a two-stage synchronizer. Each event takes effect on the first time-base edge at which the synchronized level is high after DONE release, plus its effective delay. In configuration-clock modes, if the line is first sampled high at edge A, an event with delay d takes effect at edge A+2+d.
- R4: In locked modes, while `done_sense_i` is held low externally, `gsr_o` stays 1 and `io_en_o` stays 0, even though `done_pull_o` has already released.
- R5: Delay codes 0 to 4 give that many edges. Codes 5 to 7 act as 4.
- R6: `mode_i` bit 0 selects locked mode (1) or free mode (0). Bit 1 selects the user clock (1) or the configuration clock (0) as the time base. In user-clock modes, events advance only on rising edges of `usr_clk_i` after synchronization, so any two events lie a whole number of user-clock periods apart.
- R7: The user-clock time base also applies to DONE release. The release happens on the first user-clock edge after both conditions of R1 hold, so it comes less than one user-clock period after the configuration-clock release time.
- R8: While reset is active, and from three clock edges after `prgm_ni` goes low, the outputs are `clear_o`=1, `done_pull_o`=1, `gsr_o`=1 and `io_en_o`=0. After `prgm_ni` returns high, configuration restarts and DONE is released again when the conditions of R1 hold.
- R9: Once released or enabled, each of the three events holds its state until the next reprogram pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prgm_ni | input | 1 | Reprogram request, active low, asynchronous |
| init_i | input | 1 | Initialisation done; the length count runs while high |
| frame_end_i | input | 1 | Final configuration frame has been written |
| len_count_i | input | CNT_W | Length value loaded from the configuration stream |
| mode_i | input | 2 | Bit 0: locked mode; bit 1: user-clock time base |
| rst_dly_i | input | DLY_W | Delay code for reset release |
| io_dly_i | input | DLY_W | Delay code for I/O enable |
| usr_clk_i | input | 1 | User clock, asynchronous, slower than clk_i |
| done_sense_i | input | 1 | Sensed wired-AND DONE pad level |
| done_pull_o | output | 1 | Drive the DONE pad low when 1 |
| gsr_o | output | 1 | Global set/reset to user flip-flops, active high |
| io_en_o | output | 1 | Enable user I/O drivers |
| clear_o | output | 1 | Request to clear configuration memory |

## Verification
In free mode with a delay code of 0, DONE release and an event (reset release or I/O enable) fall on the same clock edge. Both events can also fall on one edge when their delay codes are equal, and codes 5 to 7 clamp onto 4. Directed runs set zero and equal delays, and random runs mix in clamped codes. For each run, the bench records the cycle in which each output first changes and compares the recorded cycles exactly. Same-edge cases are judged by equal recorded cycles, not by order. In locked mode the bench holds the external DONE level low past DONE release to show that the other two events wait.

// File: rtl/cfg_startup_pkg.sv
package cfg_startup_pkg;
  typedef enum logic [1:0] {
    SU_CFG_FREE = 2'b00,
    SU_CFG_LOCK = 2'b01,
    SU_USR_FREE = 2'b10,
    SU_USR_LOCK = 2'b11
  } su_mode_e;

  localparam int unsigned NUM_EVT = 2;
  localparam int unsigned EVT_GSR = 0;
  localparam int unsigned EVT_IO  = 1;
endpackage

// File: rtl/cfg_startup_sync.sv
module cfg_startup_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_startup_lencnt.sv
module cfg_startup_lencnt #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             init_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             reached_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             reach_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      reach_q <= 1'b0;
    end else if (clr_i || !init_i) begin
      cnt_q   <= '0;
      reach_q <= 1'b0;
    end else begin
      if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;  // saturate
      if (cnt_q == len_i) reach_q <= 1'b1;
    end
  end

  // count passes len while frame end is late: keep the hit
  assign reached_o = init_i && !clr_i && (reach_q || (cnt_q == len_i));

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && !clr_i && (&cnt_q)) |=> (&cnt_q)); // R1
  AST_REACH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reached_o && init_i && !clr_i) |=> (reached_o || !init_i || clr_i)); // R1
endmodule

// File: rtl/cfg_startup_evt.sv
module cfg_startup_evt #(
  parameter int unsigned DLY_W   = 3,
  parameter int unsigned MAX_DLY = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             ref_hit_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);
  localparam int unsigned CW = $clog2(MAX_DLY + 2);

  logic [CW-1:0] eff_dly, cnt_q;
  logic          armed_q, fire_q;

  always_comb begin
    if (int'(dly_i) > int'(MAX_DLY)) eff_dly = CW'(MAX_DLY);
    else                             eff_dly = CW'(dly_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      fire_q  <= 1'b0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      fire_q  <= 1'b0;
    end else if (ref_hit_i) begin
      armed_q <= 1'b1;
      cnt_q   <= CW'(1);
      if (eff_dly == '0) fire_q <= 1'b1;
    end else if (armed_q && tick_i && !fire_q) begin
      if (cnt_q == eff_dly) fire_q <= 1'b1;
      if (cnt_q != CW'(MAX_DLY + 1)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire_o = fire_q;

  AST_FIRE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_q && !clr_i) |=> fire_q); // R9
  AST_FIRE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fire_q) |-> $past(tick_i)); // R6
  AST_FIRE_NEEDS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fire_q) |-> ($past(armed_q) || $past(ref_hit_i))); // R5
endmodule

// File: rtl/cfg_startup.sv
module cfg_startup
  import cfg_startup_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned DLY_W       = 3,
  parameter int unsigned MAX_DLY     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prgm_ni,
  input  logic             init_i,
  input  logic             frame_end_i,
  input  logic [CNT_W-1:0] len_count_i,
  input  logic [1:0]       mode_i,
  input  logic [DLY_W-1:0] rst_dly_i,
  input  logic [DLY_W-1:0] io_dly_i,
  input  logic             usr_clk_i,
  input  logic             done_sense_i,
  output logic             done_pull_o,
  output logic             gsr_o,
  output logic             io_en_o,
  output logic             clear_o
);
  su_mode_e mode;
  logic     locked, use_usr;
  logic     prgm_s, done_s, uclk_s, uclk_d_q;
  logic     clear, tick, reached, begin_su;
  logic     done_rel_q, ref_seen_q, rel_edge, ref_hit;
  logic [NUM_EVT-1:0] fire;
  logic [DLY_W-1:0]   dly_sel [NUM_EVT];

  assign mode    = su_mode_e'(mode_i);
  assign locked  = (mode == SU_CFG_LOCK) || (mode == SU_USR_LOCK);
  assign use_usr = (mode == SU_USR_FREE) || (mode == SU_USR_LOCK);

  cfg_startup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_prgm (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(prgm_ni), .q_o(prgm_s));
  cfg_startup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(done_sense_i), .q_o(done_s));
  cfg_startup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_uclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(usr_clk_i), .q_o(uclk_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) uclk_d_q <= 1'b0;
    else         uclk_d_q <= uclk_s;
  end

  assign clear = !prgm_s;
  assign tick  = use_usr ? (uclk_s && !uclk_d_q) : 1'b1;

  cfg_startup_lencnt #(.CNT_W(CNT_W)) u_lencnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear), .init_i(init_i),
    .len_i(len_count_i), .reached_o(reached));

  assign begin_su = reached && frame_end_i;
  assign rel_edge = begin_su && tick && !done_rel_q;
  assign ref_hit  = locked ? (done_rel_q && !ref_seen_q && done_s && tick) : rel_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_rel_q <= 1'b0;
      ref_seen_q <= 1'b0;
    end else if (clear) begin
      done_rel_q <= 1'b0;
      ref_seen_q <= 1'b0;
    end else begin
      if (rel_edge) done_rel_q <= 1'b1;
      if (ref_hit)  ref_seen_q <= 1'b1;
    end
  end

  assign dly_sel[EVT_GSR] = rst_dly_i;
  assign dly_sel[EVT_IO]  = io_dly_i;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    cfg_startup_evt #(.DLY_W(DLY_W), .MAX_DLY(MAX_DLY)) u_evt (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear), .tick_i(tick),
      .ref_hit_i(ref_hit), .dly_i(dly_sel[g]), .fire_o(fire[g]));
  end

  assign done_pull_o = !done_rel_q;
  assign gsr_o       = !fire[EVT_GSR];
  assign io_en_o     = fire[EVT_IO];
  assign clear_o     = clear;

  AST_CLEAR_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> (done_pull_o && gsr_o && !io_en_o)); // R8
  AST_RELEASE_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_pull_o) |-> $past(reached && frame_end_i)); // R1
  AST_LOCK_IO_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && $rose(io_en_o)) |-> ref_seen_q); // R4
  AST_LOCK_GSR_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && $fell(gsr_o)) |-> ref_seen_q); // R4
  AST_LOCK_DONE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && (io_en_o || !gsr_o)) |-> !done_pull_o); // R3
  AST_DONE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_pull_o && !clear_o) |=> !done_pull_o); // R9
endmodule

// File: tb/cfg_startup_bench.sv
`timescale 1ns/100ps
module cfg_startup_bench;
  localparam int CNT_W = 24;
  localparam int DLY_W = 3;

  logic clk = 1'b0, rst_n = 1'b0, prgm_n = 1'b1, init = 1'b0, frame_end = 1'b0;
  logic [CNT_W-1:0] len = '0;
  logic [1:0] mode = 2'b01;
  logic [DLY_W-1:0] rst_dly = '0, io_dly = '0;
  logic usr_clk = 1'b0, ext_hold = 1'b0;
  logic done_pull, gsr, io_en, clear;
  wire  done_sense = !done_pull && !ext_hold;

  int cyc = 0, n_chk = 0, n_fail = 0, half = 2;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (half) @(negedge clk);
    #1 usr_clk = ~usr_clk;
  end

  cfg_startup u_cfg_startup (
    .clk_i(clk), .rst_ni(rst_n), .prgm_ni(prgm_n), .init_i(init),
    .frame_end_i(frame_end), .len_count_i(len), .mode_i(mode),
    .rst_dly_i(rst_dly), .io_dly_i(io_dly), .usr_clk_i(usr_clk),
    .done_sense_i(done_sense), .done_pull_o(done_pull), .gsr_o(gsr),
    .io_en_o(io_en), .clear_o(clear));

  function automatic int eff(int d); return (d > 4) ? 4 : d; endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_cleared(string req);
    chk(clear == 1'b1, req, "clear_o", clear, 1);
    chk(done_pull == 1'b1, req, "done_pull_o", done_pull, 1);
    chk(gsr == 1'b1, req, "gsr_o", gsr, 1);
    chk(io_en == 1'b0, req, "io_en_o", io_en, 0);
  endtask

  task automatic reprogram(int m, int dr, int di, int ln, int hf);
    @(negedge clk); #1;
    prgm_n = 1'b0; init = 1'b0; frame_end = 1'b0; ext_hold = 1'b0;
    repeat (3) @(negedge clk);
    chk_cleared("R8");
    mode = 2'(m); rst_dly = DLY_W'(dr); io_dly = DLY_W'(di); len = CNT_W'(ln); half = hf;
    #1 prgm_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one start-up pass; hold = 0 means no external stall
  task automatic run(int m, int dr, int di, int ln, int fofs, int hold, int hf);
    int i0, f, hh, td, tr, ti, ue, p, per, er, ei, last;
    reprogram(m, dr, di, ln, hf);
    #1 ext_hold = (hold > 0);
    i0 = cyc + 1; f = i0 + fofs; hh = (hold > 0) ? i0 + hold : -1;
    td = -1; tr = -1; ti = -1; last = -1;
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      if (td < 0 && !done_pull) td = cyc;
      if (tr < 0 && !gsr) tr = cyc;
      if (ti < 0 && io_en) ti = cyc;
      if (last < 0 && td >= 0 && tr >= 0 && ti >= 0) last = cyc;
      if (last >= 0 && cyc >= last + 20) break;
      #1;
      if (cyc == i0) init = 1'b1;
      if (cyc == f) frame_end = 1'b1;
      if (cyc == hh) ext_hold = 1'b0;
    end
    ue = imax(i0 + ln, f) + 1; per = 2 * hf; er = eff(dr); ei = eff(di);
    p = imax(td, hh);
    case (m)
      0: begin // R6 free, configuration clock
        chk(td == ue, "R1", "done release cycle", td, ue);
        chk(tr == td + er, "R2", "reset release cycle", tr, td + er);
        chk(ti == td + ei, "R2", "io enable cycle", ti, td + ei);
      end
      1: begin // R6 locked, configuration clock
        chk(td == ue, "R1", "done release cycle", td, ue);
        chk(tr == p + 3 + er, "R3", "reset release cycle", tr, p + 3 + er);
        chk(ti == p + 3 + ei, "R3", "io enable cycle", ti, p + 3 + ei);
      end
      2: begin // R6 free, user clock
        chk(td >= ue && td < ue + per, "R7", "done release cycle", td, ue);
        chk(tr - td == er * per, "R6", "reset spacing", tr - td, er * per);
        chk(ti - td == ei * per, "R6", "io spacing", ti - td, ei * per);
      end
      default: begin // R6 locked, user clock
        chk(td >= ue && td < ue + per, "R7", "done release cycle", td, ue);
        chk(tr - ti == (er - ei) * per, "R6", "reset vs io spacing", tr - ti, (er - ei) * per);
        chk(imax(tr, ti) >= p + 3 && (tr < ti ? tr : ti) >= p + 3, "R4",
            "earliest event after external release", (tr < ti ? tr : ti), p + 3);
      end
    endcase
    if (td >= 0 && tr >= 0 && ti >= 0) begin
      chk(done_pull == 1'b0, "R9", "done_pull_o held", done_pull, 0);
      chk(gsr == 1'b0 && io_en == 1'b1, "R9", "events held", {30'd0, gsr, io_en}, 1);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_up();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk_cleared("R8");
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // directed: default-style locked run, zero delays
    run(1, 0, 0, 5, 0, 0, 2);
    // R2 same-edge: DONE and io together, reset four edges later
    run(0, 4, 0, 3, 0, 0, 2);
    // R5 clamped codes 7 and 5
    run(0, 7, 5, 0, 0, 0, 2);
    // R1 zero length, frame end late
    run(0, 1, 2, 0, 17, 0, 2);
    // R4 external hold far past release
    run(1, 2, 1, 2, 0, 40, 2);
    // R7 user clock, both modes
    run(2, 3, 1, 4, 2, 0, 3);
    run(3, 0, 2, 4, 0, 25, 2);
    for (int r = 0; r < 30; r++) begin
      run(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
          int'($urandom_range(0, 40)), int'($urandom_range(0, 40)),
          ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, 60)) : 0,
          int'($urandom_range(2, 4)));
    end
    // R8 reprogram after a completed pass
    reprogram(0, 0, 0, 1, 2);
    repeat (2) @(negedge clk);
    chk(done_pull == 1'b1 && gsr == 1'b1 && io_en == 1'b0, "R8",
        "idle after reprogram without init", {29'd0, done_pull, gsr, io_en}, 6);
    finish_up();
  end
endmodule